// File: doc/BRIEF.md
# Multi-Channel PWM with Handshaked Parameter Update

This block is a bank of independent pulse-width modulators. Each channel has one control word. The control word holds four things: a phase step, a duty threshold, an enable flag and an update-request flag. Software writes a step and a threshold into shadow storage. They reach the running generator only through the update request. After the write that sets the request, the request flag stays set for a fixed number of cycles. At the end of that delay the shadow values move into the active registers and the flag clears by itself. Software can poll the flag to see when the copy has happened.

Each generator adds its active step to a 16-bit phase accumulator on every clock. The output is high while the top byte of the accumulator is below the active threshold. New values can be applied while the output runs. The accumulator is never reset by an update, so the waveform carries on without a break.

The write path tolerates a read-modify-write of the enable flag that writes back a request bit still reading 1. A second request that arrives while one is pending joins it. It does not extend the pending request and it cannot leave the flag stuck.

Top module: `pwm_bank`

## Requirements
- R1: After reset every control word reads 0 and every output is low.
- R2: The control word layout is: bits [BU_W-1:0] step, bits [BU_W+7:BU_W] threshold, bit BU_W+8 update request, bit BU_W+9 enable. A read returns the shadow step and threshold, the enable flag and the live request flag.
- R3: Writing the step or threshold with the request bit at 0 leaves the output waveform unchanged.
- R4: A write with the request bit at 1 makes the flag read 1 for exactly UPD_DLY cycles (4 by default) after that write. After that the flag reads 0.
- R5: The shadow values take effect on the clock edge that clears the request. The accumulator keeps its value across that edge.
- R6: A request written while one is pending does not restart the delay. The flag clears at the time set by the first request, and the shadow values present at that time are loaded.
- R7: While enabled, a channel adds its active step to its accumulator every clock. The output is high exactly when the accumulator's top byte is below the active threshold.
- R8: While enable is 0 the output is low and the accumulator is held at zero, so re-enabling starts the waveform from phase zero.
- R9: A write to one channel changes no other channel's control word or output.
- R10: Parameters can be updated while enabled, without toggling enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one control word |
| wr_ch_i | input | CH_W | Channel addressed by the write |
| wr_data_i | input | CTRL_W | Control word to write |
| rd_ch_i | input | CH_W | Channel addressed by the read |
| rd_data_o | output | CTRL_W | Control word of the addressed channel, combinational |
| pwm_o | output | N_CH | One waveform output per channel |

## Verification
A wrong delay count shows up on the read port. The request flag clears one cycle early or late, within UPD_DLY cycles of the write. A stuck flag never clears at all. If the copy goes wrong or the accumulator is reset on an update, the output shows it. The duty pattern drifts from a phase-continuous reference within a few output periods of the update. A merge that restarts the delay shows up as a late clear on the read port at the exact cycle the first request should have ended.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ACC_W  = 16;
  localparam int DUTY_W = 8;

  function automatic int ctrl_w(input int bu_w);
    return bu_w + DUTY_W + 2;
  endfunction
endpackage

// File: rtl/pwm_upd_ctrl.sv
module pwm_upd_ctrl #(
  parameter int DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pend_o,
  output logic load_o
);
  localparam int CNT_W = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY - 1);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = pend_q && (cnt_q == LAST);
  assign pend_o = pend_q;

  // request during the load cycle opens a fresh request so its values are not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      pend_q <= req_i;
      cnt_q  <= '0;
    end else if (pend_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end else if (req_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  AST_REQ_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !pend_q) |=> pend_q); // R4
  AST_PEND_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_q == LAST && !req_i) |=> !pend_q); // R4
  AST_MERGE_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && req_i && cnt_q != LAST) |=> (pend_q && cnt_q == $past(cnt_q) + 1'b1)); // R6
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int BU_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BU_W-1:0]   step_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= acc_q + ACC_W'(step_i);
  end

  assign pwm_o = en_i && (acc_q[ACC_W-1 -: DUTY_W] < duty_i);

  AST_ACC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0)); // R8
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int BU_W    = 8,
  parameter int UPD_DLY = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [ctrl_w(BU_W)-1:0] wdata_i,
  output logic [ctrl_w(BU_W)-1:0] rdata_o,
  output logic                    pwm_o
);
  localparam int UPD_BIT = BU_W + DUTY_W;
  localparam int EN_BIT  = UPD_BIT + 1;

  logic [BU_W-1:0]   sh_bu_q,  act_bu_q;
  logic [DUTY_W-1:0] sh_div_q, act_div_q;
  logic              en_q, pend, load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_bu_q  <= '0;
      sh_div_q <= '0;
      en_q     <= 1'b0;
    end else if (wr_i) begin
      sh_bu_q  <= wdata_i[BU_W-1:0];
      sh_div_q <= wdata_i[UPD_BIT-1:BU_W];
      en_q     <= wdata_i[EN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_bu_q  <= '0;
      act_div_q <= '0;
    end else if (load) begin
      act_bu_q  <= sh_bu_q;
      act_div_q <= sh_div_q;
    end
  end

  pwm_upd_ctrl #(.DLY(UPD_DLY)) u_upd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (wr_i && wdata_i[UPD_BIT]),
    .pend_o (pend),
    .load_o (load)
  );

  pwm_gen #(.BU_W(BU_W)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .step_i (act_bu_q),
    .duty_i (act_div_q),
    .pwm_o  (pwm_o)
  );

  assign rdata_o = {en_q, pend, sh_div_q, sh_bu_q};

  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> ($stable(act_bu_q) && $stable(act_div_q))); // R3
  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (act_bu_q == $past(sh_bu_q) && act_div_q == $past(sh_div_q))); // R5
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !pwm_o); // R8
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int N_CH    = 4,
  parameter int BU_W    = 8,
  parameter int UPD_DLY = 4,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int CTRL_W = ctrl_w(BU_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic [N_CH-1:0]   pwm_o
);
  logic [CTRL_W-1:0] rd_bus [N_CH];
  logic [N_CH-1:0]   wr_hit;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign wr_hit[c] = wr_en_i && (wr_ch_i == CH_W'(c));

    pwm_chan #(.BU_W(BU_W), .UPD_DLY(UPD_DLY)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_hit[c]),
      .wdata_i (wr_data_i),
      .rdata_o (rd_bus[c]),
      .pwm_o   (pwm_o[c])
    );
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < N_CH; c++)
      if (rd_ch_i == CH_W'(c)) rd_data_o = rd_bus[c];
  end

  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit)); // R9
endmodule

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
  localparam int N_CH = 4, BU_W = 8, DLY = 4, CW = 18;

  logic clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_ch = '0, rd_ch = '0;
  logic [CW-1:0] wr_data = '0, rd_data;
  logic [N_CH-1:0] pwm;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_bank #(.N_CH(N_CH), .BU_W(BU_W), .UPD_DLY(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_data_i(wr_data), .rd_ch_i(rd_ch), .rd_data_o(rd_data), .pwm_o(pwm));

  // reference model of the tracked channel
  int m_ch = 0, m_cd = 0, mism = 0;
  logic [15:0] m_acc = '0;
  logic [7:0] m_bu = '0, m_div = '0, n_bu = '0, n_div = '0;
  logic m_en = 0, m_en_nx = 0;
  logic [N_CH-1:0] f_act = '0, f_exp = '0;

  function automatic logic [CW-1:0] mk(input logic en, upd, input logic [7:0] dv, bu);
    return {en, upd, dv, bu};
  endfunction

  task automatic chk(input string tag, input logic [CW-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int ch, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_data = d;
    if (ch == m_ch) begin
      m_en_nx = d[17];
      if (d[16]) begin n_bu = d[7:0]; n_div = d[15:8]; if (m_cd == 0) m_cd = DLY + 1; end
    end
  endtask

  task automatic step();
    logic [N_CH-1:0] e;
    @(negedge clk);
    wr_en = 1'b0;
    if (m_en) m_acc = m_acc + 16'(m_bu); else m_acc = '0;
    m_en = m_en_nx;
    if (m_cd > 0) begin
      m_cd--;
      if (m_cd == 0) begin m_bu = n_bu; m_div = n_div; end
    end
    e = '0;
    e[m_ch] = m_en && (m_acc[15:8] < m_div);
    if (pwm !== e && mism == 0) begin f_act = pwm; f_exp = e; end
    if (pwm !== e) mism++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic seg_check(input string tag);
    n_chk++;
    if (mism != 0) begin
      n_err++;
      $display("FAIL %s waveform: %0d bad cycles, first actual=%b expected=%b", tag, mism, f_act, f_exp);
    end
    mism = 0;
  endtask

  task automatic rd_upd(input int ch, input logic exp, input string tag);
    rd_ch = 2'(ch); #1;
    chk(tag, CW'(rd_data[16]), CW'(exp));
  endtask

  task automatic track(input int ch);
    m_ch = ch; m_acc = '0; m_en = 0; m_en_nx = 0; m_cd = 0; m_bu = '0; m_div = '0;
  endtask

  // {channel, step, threshold}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 8'd255, 8'd128}, {2'd1, 8'd64, 8'd0},  {2'd2, 8'd200, 8'd255},
    {2'd3, 8'd17, 8'd50},   {2'd0, 8'd1, 8'd1},   {2'd1, 8'd128, 8'd64}};

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm", CW'(pwm), '0);
    for (int c = 0; c < N_CH; c++) begin
      rd_ch = 2'(c); #1;
      chk("R1 read", rd_data, '0);
    end

    // R7 R9 vector walk: first-activation flow, then run against the model
    for (int v = 0; v < 6; v++) begin
      track(int'(VEC[v][17:16]));
      drive(m_ch, mk(0, 1, VEC[v][7:0], VEC[v][15:8]));
      steps(DLY);
      rd_upd(m_ch, 1'b1, "R4 still pending before clear");
      step();
      rd_upd(m_ch, 1'b0, "R4 cleared after delay");
      drive(m_ch, mk(1, 0, VEC[v][7:0], VEC[v][15:8]));
      steps(300);
      drive(m_ch, mk(0, 0, VEC[v][7:0], VEC[v][15:8]));
      steps(3);
      seg_check("R7 R9 vector waveform");
    end

    // R3 R2: shadow write without request leaves waveform alone
    track(0);
    drive(0, mk(0, 1, 8'h80, 8'h40)); steps(DLY + 1);
    drive(0, mk(1, 0, 8'h80, 8'h40)); steps(50);
    drive(0, mk(1, 0, 8'h10, 8'h90)); steps(60);
    seg_check("R3 shadow-only write");
    rd_ch = 2'd0; #1;
    chk("R2 readback", rd_data, mk(1, 0, 8'h10, 8'h90));

    // R4 R5 R10: update while running, exact clear timing, phase continuity
    drive(0, mk(1, 1, 8'h10, 8'h90));
    for (int k = 0; k < DLY; k++) begin
      step();
      rd_upd(0, 1'b1, "R4 flag high during delay");
    end
    step();
    rd_upd(0, 1'b0, "R4 flag low after delay");
    steps(300);
    seg_check("R5 R10 live update continuity");

    // R6: racing read-modify-write merges into pending request
    drive(0, mk(1, 1, 8'h60, 8'h30));
    step(); step();
    drive(0, mk(1, 1, 8'hC0, 8'h30));
    step(); step();
    rd_upd(0, 1'b1, "R6 pending before first deadline");
    step();
    rd_upd(0, 1'b0, "R6 clears at first deadline");
    steps(5);
    rd_upd(0, 1'b0, "R6 flag not stuck");
    steps(200);
    seg_check("R6 merged values loaded");

    // R8: disable holds low and resets phase
    drive(0, mk(0, 0, 8'hC0, 8'h30)); steps(20);
    chk("R8 low when disabled", CW'(pwm[0]), '0);
    drive(0, mk(1, 0, 8'hC0, 8'h30)); steps(150);
    seg_check("R8 restart from phase zero");

    // R9: untouched channel word intact
    rd_ch = 2'd3; #1;
    chk("R9 other channel word", rd_data, mk(0, 0, 8'd50, 8'd17));

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule